// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Chain

This block is a row of interrupt slices. The slices share one request line to a processor and one acknowledge line from it. Each slice holds a pending flag, which a one-cycle pulse on its own request input sets. The processor sees the OR of all pending flags on a single request output.

When the processor raises acknowledge, a priority enable enters the slice nearest the processor and passes down the row. A slice passes the enable onward only when it has nothing pending. The first pending slice takes the enable and clears its own flag. One cycle later the block places that slice's fixed vector on the shared vector bus, with a valid flag. The processor uses the vector to go directly to the matching service routine.

Priority depends only on position in the row. No mask, rotation or software setting changes it.

Top module: `irq_daisy_chain`

## Requirements
- R1: While reset is asserted, and after it is released with no request seen, `irq_o` is 0, `vec_valid_o` is 0 and `vec_o` is 0.
- R2: A one-cycle high pulse on `req_i[k]` sets the pending flag of slice k. The flag stays set until that slice is acknowledged, and `irq_o` is 1 while any flag is set.
- R3: An acknowledge is accepted only in a cycle where `ack_i` is 1 and was 0 in the cycle before. Holding `ack_i` high for further cycles grants nothing more.
- R4: In the cycle after an accepted acknowledge that finds a pending slice, `vec_valid_o` is 1 for exactly one cycle.
- R5: The winning slice is the pending slice with the lowest index. Index 0 sits nearest the processor. Higher-index pending slices keep their flags.
- R6: The granted slice clears its pending flag. `irq_o` drops to 0 when no other flag remains.
- R7: An accepted acknowledge that finds no pending slice leaves `vec_valid_o` at 0 and `vec_o` at 0.
- R8: A request pulse in the same cycle as an accepted acknowledge does not win that acknowledge. It stays pending for the next one. This also applies when the pulse is on the slice being granted.
- R9: `vec_o` is all zeros whenever `vec_valid_o` is 0.
- R10: The vector of slice k is `VEC_TABLE[k*VEC_W +: VEC_W]`. With default parameters, slices 0 to 3 give 0x13, 0x2C, 0x35 and 0x47.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_SLICES | Per-slice request pulses |
| ack_i | input | 1 | Acknowledge from the processor |
| irq_o | output | 1 | Shared request line, OR of all pending flags |
| vec_o | output | VEC_W | Vector of the granted slice |
| vec_valid_o | output | 1 | Vector bus valid, one cycle per grant |

## Verification
The checker tests several rules on every cycle:
- a valid vector only follows an acknowledge seen with the request line high;
- valid never lasts two cycles;
- the vector bus is zero when valid is low;
- the request line never rises without a request pulse;
- every accepted acknowledge with something pending yields a vector.

Only the bench scenarios can show which slice wins. They raise several requests together and check that the vectors come out strictly in position order. They also show that a request arriving during an acknowledge waits for the next one, and that the table maps each slice to the right vector.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int unsigned DEF_SLICES = 4;
  localparam int unsigned DEF_VEC_W  = 8;
  localparam logic [DEF_SLICES*DEF_VEC_W-1:0] DEF_TABLE = {8'h47, 8'h35, 8'h2C, 8'h13};
endpackage

// File: rtl/irq_ack_edge.sv
module irq_ack_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic start_o
);
  logic ack_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= ack_i;
  end
  assign start_o = ack_i & ~ack_q;
endmodule

// File: rtl/irq_slice.sv
module irq_slice (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic en_i,
  output logic en_o,
  output logic grant_o,
  output logic pend_o
);
  logic pend_q;
  assign grant_o = en_i & pend_q;
  assign en_o    = en_i & ~pend_q;
  assign pend_o  = pend_q;
  // a fresh pulse wins over the clear, so it is kept for the next grant
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (req_i)   pend_q <= 1'b1;
    else if (grant_o) pend_q <= 1'b0;
  end
endmodule

// File: rtl/irq_vec_drive.sv
module irq_vec_drive #(
  parameter int unsigned NUM_SLICES = 4,
  parameter int unsigned VEC_W      = 8,
  parameter logic [NUM_SLICES*VEC_W-1:0] VEC_TABLE = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_SLICES-1:0] grant_i,
  output logic [VEC_W-1:0]      vec_o,
  output logic                  valid_o
);
  logic [VEC_W-1:0] bus_d;
  always_comb begin
    bus_d = '0;
    for (int k = 0; k < int'(NUM_SLICES); k++)
      if (grant_i[k]) bus_d = bus_d | VEC_TABLE[k*VEC_W +: VEC_W];
  end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      vec_o   <= bus_d;
      valid_o <= |grant_i;
    end
  end
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain
  import irq_chain_pkg::*;
#(
  parameter int unsigned NUM_SLICES = DEF_SLICES,
  parameter int unsigned VEC_W      = DEF_VEC_W,
  parameter logic [NUM_SLICES*VEC_W-1:0] VEC_TABLE = DEF_TABLE
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_SLICES-1:0] req_i,
  input  logic                  ack_i,
  output logic                  irq_o,
  output logic [VEC_W-1:0]      vec_o,
  output logic                  vec_valid_o
);
  logic                  ack_start;
  logic [NUM_SLICES:0]   en_chain;
  logic [NUM_SLICES-1:0] grant;
  logic [NUM_SLICES-1:0] pend;

  irq_ack_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (ack_i),
    .start_o(ack_start)
  );

  assign en_chain[0] = ack_start;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    irq_slice u_slice (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req_i[k]),
      .en_i   (en_chain[k]),
      .en_o   (en_chain[k+1]),
      .grant_o(grant[k]),
      .pend_o (pend[k])
    );
  end

  assign irq_o = |pend;

  irq_vec_drive #(
    .NUM_SLICES(NUM_SLICES),
    .VEC_W     (VEC_W),
    .VEC_TABLE (VEC_TABLE)
  ) u_vec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .grant_i(grant),
    .vec_o  (vec_o),
    .valid_o(vec_valid_o)
  );
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
  parameter int unsigned NUM_SLICES = 4,
  parameter int unsigned VEC_W      = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_SLICES-1:0] req_i,
  input logic                  ack_i,
  input logic                  irq_o,
  input logic [VEC_W-1:0]      vec_o,
  input logic                  vec_valid_o
);
  logic ack_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_seen_q <= 1'b0;
    else         ack_seen_q <= ack_i;
  end

  a_r4_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> !vec_valid_o);
  a_r3_valid_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> ($past(ack_i) && $past(irq_o)));
  a_r9_bus_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_valid_o |-> (vec_o == '0));
  a_r2_no_spurious_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && (req_i == '0)) |=> !irq_o);
  a_r4_ack_yields_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !ack_seen_q && irq_o) |=> vec_valid_o);
endmodule

bind irq_daisy_chain irq_chain_chk #(
  .NUM_SLICES(NUM_SLICES),
  .VEC_W     (VEC_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .ack_i      (ack_i),
  .irq_o      (irq_o),
  .vec_o      (vec_o),
  .vec_valid_o(vec_valid_o)
);

// File: tb/tb_irq_daisy_chain.sv
module tb_irq_daisy_chain;
  localparam int N = 4;
  localparam int W = 8;

  typedef struct packed {
    logic [N-1:0] req;
    logic [W-1:0] vec;
    logic         valid;
    logic         irq_after;
  } row_t;

  localparam int ROWS = 8;
  localparam row_t TABLE [ROWS] = '{
    '{4'b0101, 8'h13, 1'b1, 1'b1},
    '{4'b0000, 8'h35, 1'b1, 1'b0},
    '{4'b0000, 8'h00, 1'b0, 1'b0},
    '{4'b1000, 8'h47, 1'b1, 1'b0},
    '{4'b1110, 8'h2C, 1'b1, 1'b1},
    '{4'b0000, 8'h35, 1'b1, 1'b1},
    '{4'b0001, 8'h13, 1'b1, 1'b1},
    '{4'b0000, 8'h47, 1'b1, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         ack = 1'b0;
  logic         irq;
  logic [W-1:0] vec;
  logic         vld;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  irq_daisy_chain dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ack_i(ack),
    .irq_o(irq), .vec_o(vec), .vec_valid_o(vld)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_req(input logic [N-1:0] m);
    @(negedge clk) req = m;
    @(negedge clk) req = '0;
  endtask

  // ack rises with optional same-cycle request; samples vector one cycle later
  task automatic do_ack(input logic [N-1:0] same_req, input logic [W-1:0] exp_vec,
                        input logic exp_vld, input logic exp_irq);
    @(negedge clk) begin ack = 1'b1; req = same_req; end
    @(negedge clk) begin
      req = '0;
      chk("R4/R5/R10 valid", vld, exp_vld);
      chk("R5/R10/R7 vector", vec, exp_vec);
    end
    @(negedge clk) begin
      chk("R3/R4 held ack no second grant", vld, 1'b0);
      chk("R9 bus zero", vec, '0);
      chk("R6 irq after grant", irq, exp_irq);
      ack = 1'b0;
    end
  endtask

  initial begin
    #3;
    chk("R1 irq in reset", irq, 1'b0);
    chk("R1 valid in reset", vld, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 vec after reset", vec, '0);
    chk("R1 irq after reset", irq, 1'b0);

    for (int i = 0; i < ROWS; i++) begin
      if (TABLE[i].req != '0) pulse_req(TABLE[i].req);
      do_ack('0, TABLE[i].vec, TABLE[i].valid, TABLE[i].irq_after);
    end

    // R2: pending flag persists without ack
    pulse_req(4'b0010);
    repeat (5) @(negedge clk);
    chk("R2 pending held", irq, 1'b1);
    // R8: slice0 pulse during ack loses to already pending slice1
    do_ack(4'b0001, 8'h2C, 1'b1, 1'b1);
    do_ack('0, 8'h13, 1'b1, 1'b0);
    // R8: re-request on the winner in the grant cycle is kept
    pulse_req(4'b0100);
    do_ack(4'b0100, 8'h35, 1'b1, 1'b1);
    do_ack('0, 8'h35, 1'b1, 1'b0);
    // R7: empty acknowledge
    do_ack('0, 8'h00, 1'b0, 1'b0);
    // R3: ack high without a fresh edge grants nothing
    @(negedge clk) ack = 1'b1;
    @(negedge clk) req = 4'b1000;
    @(negedge clk) req = '0;
    repeat (2) @(negedge clk);
    chk("R3 no grant without edge", vld, 1'b0);
    chk("R3 request still pending", irq, 1'b1);
    ack = 1'b0;
    do_ack('0, 8'h47, 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #100000;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule